// File: doc/BRIEF.md
# PS/2 Device-Side Receiver with Acknowledge

This block sits on the device end of a PS/2 link and accepts bytes that the host sends. While the bus is idle it watches the clock and data lines. When the host has held the clock low and then releases it with data already pulled low, that is a request to send. The block then produces twelve clock pulses of its own on the open-drain clock line. In them it samples the start bit, eight data bits (least significant first), an odd parity bit and the stop bit. On the twelfth pulse it pulls data low as the acknowledge.

An acknowledge policy input chooses between two behaviours. With the policy at 0, every frame is acknowledged. With the policy at 1, a frame whose parity is wrong or whose stop bit is 0 gets no acknowledge and is dropped. An accepted byte moves into a holding register at the end of the twelfth pulse. At the same point the block updates the received-parity copy, the receive interrupt flag and the overwrite tracking. Frame error, overwrite and the receive interrupt flag are sticky, and each one is cleared by its own one-cycle clear strobe. A read strobe marks the holding register as consumed.

Top module: `ps2_dev_rx`

## Requirements
- R1: While enabled and idle, a frame starts only when the synchronised clock is seen high with synchronised data low, after a cycle in which the synchronised clock was low. A clock release with data high starts no frame.
- R2: A frame consists of exactly 12 device clock pulses. Each pulse holds `clk_drive_low` at 1 for HALF_CYC cycles and then at 0 for HALF_CYC cycles.
- R3: Pulse 1 samples the start bit. Pulses 2 to 9 sample data bits 0 to 7, least significant bit first. An accepted byte appears on `rx_data` after pulse 12 ends.
- R4: `rx_parity` holds the parity bit (pulse 10) of the last accepted byte. Parity is odd: data plus parity hold an odd number of ones.
- R5: With `ack_policy`=0, `dat_drive_low` is 1 throughout pulse 12 for every frame, including frames with a bad parity bit.
- R6: With `ack_policy`=1, a frame with wrong parity or a stop bit of 0 gets no acknowledge (`dat_drive_low` stays 0). Its byte is not transferred, and the interrupt flag does not set.
- R7: A stop bit (pulse 11) sampled as 0 sets `frame_err`. The flag stays set until a `clr_frame_err` pulse clears it.
- R8: Accepting a byte while the previous one is unread (no `rd_strobe` since it arrived) sets `overwrite` and replaces `rx_data`. A read in between prevents this. `clr_overwrite` clears the flag.
- R9: `rx_irq_flag` sets when an acknowledged byte is accepted and clears on `clr_rx_irq`. `rx_irq` equals the flag gated by `rx_irq_en`.
- R10: `rx_busy` is 1 from the frame start until pulse 12 ends, and 0 when idle.
- R11: `clk_pin_state` and `dat_pin_state` follow the line inputs through a two-flop synchroniser that resets to 1.
- R12: While `enable` is 0, the block drives neither line and ignores requests to send. Dropping `enable` mid-frame releases both lines on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable |
| ack_policy | input | 1 | 0: always acknowledge; 1: withhold acknowledge on parity or stop error |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle pulse: holding register has been read |
| clr_frame_err | input | 1 | One-cycle pulse clearing frame_err |
| clr_overwrite | input | 1 | One-cycle pulse clearing overwrite |
| clr_rx_irq | input | 1 | One-cycle pulse clearing rx_irq_flag |
| clk_line_in | input | 1 | Raw level of the PS/2 clock line |
| dat_line_in | input | 1 | Raw level of the PS/2 data line |
| clk_drive_low | output | 1 | 1 pulls the clock line low |
| dat_drive_low | output | 1 | 1 pulls the data line low (acknowledge) |
| rx_data | output | 8 | Holding register with the last accepted byte |
| rx_parity | output | 1 | Parity bit of the last accepted byte |
| frame_err | output | 1 | Sticky stop-bit error flag |
| overwrite | output | 1 | Sticky unread-byte overwrite flag |
| rx_busy | output | 1 | Frame in progress |
| rx_irq_flag | output | 1 | Sticky receive interrupt flag |
| rx_irq | output | 1 | Interrupt request (flag gated by enable) |
| clk_pin_state | output | 1 | Synchronised clock line level |
| dat_pin_state | output | 1 | Synchronised data line level |

## Verification
The bench plays the host. It sends frames with good data, a flipped parity bit and a zero stop bit, under both acknowledge policies. A design that acknowledged unconditionally would show an acknowledge and a new `rx_data` where policy 1 must reject the frame. A design that sampled bits one pulse out of step would return a shifted byte. The bench also releases the clock with data high, and raises a request while disabled; a detector keyed on the clock edge alone would start a spurious frame there. Two back-to-back frames with and without an intervening read separate correct overwrite tracking from a design that flags every second byte or never flags at all.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;

  localparam int unsigned FRAME_PULSES = 12;

  typedef enum logic [2:0] {
    ROLE_START,
    ROLE_DATA,
    ROLE_PARITY,
    ROLE_STOP,
    ROLE_ACK
  } bit_role_e;

  // Role of the line during device clock pulse number idx (1-based)
  function automatic bit_role_e pulse_role(input logic [3:0] idx);
    if (idx == 4'd1)       return ROLE_START;
    else if (idx <= 4'd9)  return ROLE_DATA;
    else if (idx == 4'd10) return ROLE_PARITY;
    else if (idx == 4'd11) return ROLE_STOP;
    else                   return ROLE_ACK;
  endfunction

  // Odd parity: data and parity together carry an odd count of ones
  function automatic logic parity_good(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction

  // Decision taken after the stop bit: 1 means drive the acknowledge
  function automatic logic ack_decision(input logic policy, input logic par_ok,
                                        input logic stop_bit);
    return !policy || (par_ok && stop_bit);
  endfunction

endpackage

// File: rtl/ps2r_sync.sv
module ps2r_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ps2r_clkgen.sv
module ps2r_clkgen
  import ps2r_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  output logic       active,
  output logic       low_phase,
  output logic       sample_stb,
  output logic [3:0] pulse_idx
);
  localparam int unsigned PERIOD = 2 * HALF_CYC;
  localparam int unsigned CW     = $clog2(PERIOD);

  logic [CW-1:0] cnt;

  assign sample_stb = active && (cnt == CW'(PERIOD - 1));
  assign low_phase  = active && (cnt < CW'(HALF_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      pulse_idx <= 4'd0;
    end else if (abort) begin
      active    <= 1'b0;
      cnt       <= '0;
    end else if (start) begin
      active    <= 1'b1;
      cnt       <= '0;
      pulse_idx <= 4'd1;
    end else if (active) begin
      if (sample_stb) begin
        cnt <= '0;
        if (pulse_idx == 4'(FRAME_PULSES)) active <= 1'b0;
        else                               pulse_idx <= pulse_idx + 4'd1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/ps2r_status.sv
module ps2r_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [7:0] new_byte,
  input  logic       new_parity,
  input  logic       stop_bad,
  input  logic       rd_strobe,
  input  logic       clr_frame_err,
  input  logic       clr_overwrite,
  input  logic       clr_rx_irq,
  output logic [7:0] hold_q,
  output logic       parity_q,
  output logic       full_q,
  output logic       frame_err_q,
  output logic       overwrite_q,
  output logic       irq_flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= 8'h00;
      parity_q    <= 1'b0;
      full_q      <= 1'b0;
      frame_err_q <= 1'b0;
      overwrite_q <= 1'b0;
      irq_flag_q  <= 1'b0;
    end else begin
      if (commit) begin
        hold_q   <= new_byte;
        parity_q <= new_parity;
        full_q   <= 1'b1;
      end else if (rd_strobe) begin
        full_q   <= 1'b0;
      end
      // set wins over a clear in the same cycle
      if (commit && full_q && !rd_strobe) overwrite_q <= 1'b1;
      else if (clr_overwrite)             overwrite_q <= 1'b0;
      if (stop_bad)           frame_err_q <= 1'b1;
      else if (clr_frame_err) frame_err_q <= 1'b0;
      if (commit)          irq_flag_q <= 1'b1;
      else if (clr_rx_irq) irq_flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ps2_dev_rx.sv
module ps2_dev_rx
  import ps2r_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 4000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       ack_policy,
  input  logic       rx_irq_en,
  input  logic       rd_strobe,
  input  logic       clr_frame_err,
  input  logic       clr_overwrite,
  input  logic       clr_rx_irq,
  input  logic       clk_line_in,
  input  logic       dat_line_in,
  output logic       clk_drive_low,
  output logic       dat_drive_low,
  output logic [7:0] rx_data,
  output logic       rx_parity,
  output logic       frame_err,
  output logic       overwrite,
  output logic       rx_busy,
  output logic       rx_irq_flag,
  output logic       rx_irq,
  output logic       clk_pin_state,
  output logic       dat_pin_state
);
  logic [1:0] sync_q;
  logic       clk_s, dat_s;

  ps2r_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({dat_line_in, clk_line_in}),
    .d_out (sync_q)
  );
  assign clk_s = sync_q[0];
  assign dat_s = sync_q[1];

  // Named internal events (observed by the checker)
  logic       active, low_phase, sample_stb;
  logic [3:0] pulse_idx;
  logic       seen_low_q;
  logic       rts_start, abort_evt, stop_bad_evt, commit_evt;
  logic [7:0] shift_q;
  logic       par_q, ack_go_q, hold_full;
  bit_role_e  role;

  assign rts_start = enable && !active && seen_low_q && clk_s && !dat_s;
  assign abort_evt = !enable && active;
  assign role      = pulse_role(pulse_idx);

  ps2r_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rts_start),
    .abort      (abort_evt),
    .active     (active),
    .low_phase  (low_phase),
    .sample_stb (sample_stb),
    .pulse_idx  (pulse_idx)
  );

  // Host inhibit tracking while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen_low_q <= 1'b0;
    else if (!enable || active) seen_low_q <= 1'b0;
    else if (!clk_s)            seen_low_q <= 1'b1;
    else                        seen_low_q <= 1'b0;
  end

  assign stop_bad_evt = sample_stb && (role == ROLE_STOP) && !dat_s;
  assign commit_evt   = sample_stb && (role == ROLE_ACK) && ack_go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= 8'h00;
      par_q    <= 1'b0;
      ack_go_q <= 1'b0;
    end else if (rts_start) begin
      ack_go_q <= 1'b0;
    end else if (sample_stb) begin
      unique case (role)
        ROLE_DATA:   shift_q  <= {dat_s, shift_q[7:1]};
        ROLE_PARITY: par_q    <= dat_s;
        ROLE_STOP:   ack_go_q <= ack_decision(ack_policy,
                                              parity_good(shift_q, par_q), dat_s);
        default:     ;
      endcase
    end
  end

  ps2r_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit        (commit_evt),
    .new_byte      (shift_q),
    .new_parity    (par_q),
    .stop_bad      (stop_bad_evt),
    .rd_strobe     (rd_strobe),
    .clr_frame_err (clr_frame_err),
    .clr_overwrite (clr_overwrite),
    .clr_rx_irq    (clr_rx_irq),
    .hold_q        (rx_data),
    .parity_q      (rx_parity),
    .full_q        (hold_full),
    .frame_err_q   (frame_err),
    .overwrite_q   (overwrite),
    .irq_flag_q    (rx_irq_flag)
  );

  assign clk_drive_low = low_phase;
  assign dat_drive_low = active && (role == ROLE_ACK) && ack_go_q;
  assign rx_busy       = active;
  assign rx_irq        = rx_irq_flag && rx_irq_en;
  assign clk_pin_state = clk_s;
  assign dat_pin_state = dat_s;
endmodule

// File: rtl/ps2r_chk.sv
module ps2r_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       ack_policy,
  input logic       rd_strobe,
  input logic       clk_drive_low,
  input logic       dat_drive_low,
  input logic       rx_busy,
  input logic       rx_irq_flag,
  input logic       overwrite,
  input logic       frame_err,
  input logic [7:0] rx_data,
  input logic [7:0] shift_q,
  input logic       commit_evt,
  input logic       stop_bad_evt,
  input logic       hold_full
);
  // R5
  ack_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_drive_low |-> rx_busy);

  // R3
  byte_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> rx_data == $past(shift_q));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> rx_irq_flag);

  // R8
  overwrite_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt && hold_full && !rd_strobe |=> overwrite);

  // R7
  frame_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bad_evt |=> frame_err);

  // R6
  no_ack_bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bad_evt && ack_policy |=> !dat_drive_low);

  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !clk_drive_low && !dat_drive_low);
endmodule

bind ps2_dev_rx ps2r_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .ack_policy    (ack_policy),
  .rd_strobe     (rd_strobe),
  .clk_drive_low (clk_drive_low),
  .dat_drive_low (dat_drive_low),
  .rx_busy       (rx_busy),
  .rx_irq_flag   (rx_irq_flag),
  .overwrite     (overwrite),
  .frame_err     (frame_err),
  .rx_data       (rx_data),
  .shift_q       (shift_q),
  .commit_evt    (commit_evt),
  .stop_bad_evt  (stop_bad_evt),
  .hold_full     (hold_full)
);

// File: tb/ps2_dev_rx_tb_top.sv
module ps2_dev_rx_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, ack_policy = 1'b0, rx_irq_en = 1'b0;
  logic rd_strobe = 1'b0, clr_frame_err = 1'b0, clr_overwrite = 1'b0, clr_rx_irq = 1'b0;
  logic host_clk = 1'b1, host_dat = 1'b1;
  logic clk_drive_low, dat_drive_low, rx_parity, frame_err, overwrite;
  logic rx_busy, rx_irq_flag, rx_irq, clk_pin_state, dat_pin_state;
  logic [7:0] rx_data;
  logic clk_line, dat_line;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  // wired-AND open-drain lines
  assign clk_line = host_clk & ~clk_drive_low;
  assign dat_line = host_dat & ~dat_drive_low;

  ps2_dev_rx #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ack_policy(ack_policy),
    .rx_irq_en(rx_irq_en), .rd_strobe(rd_strobe), .clr_frame_err(clr_frame_err),
    .clr_overwrite(clr_overwrite), .clr_rx_irq(clr_rx_irq),
    .clk_line_in(clk_line), .dat_line_in(dat_line),
    .clk_drive_low(clk_drive_low), .dat_drive_low(dat_drive_low),
    .rx_data(rx_data), .rx_parity(rx_parity), .frame_err(frame_err),
    .overwrite(overwrite), .rx_busy(rx_busy), .rx_irq_flag(rx_irq_flag),
    .rx_irq(rx_irq), .clk_pin_state(clk_pin_state), .dat_pin_state(dat_pin_state)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_strobe(input int which);
    @(negedge clk);
    case (which)
      0: rd_strobe = 1'b1;
      1: clr_frame_err = 1'b1;
      2: clr_overwrite = 1'b1;
      default: clr_rx_irq = 1'b1;
    endcase
    @(negedge clk);
    rd_strobe = 1'b0; clr_frame_err = 1'b0; clr_overwrite = 1'b0; clr_rx_irq = 1'b0;
  endtask

  // Host side of one request-to-send frame
  task automatic host_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop,
                            output int pulses, output int low_w, output logic ack_seen,
                            output logic busy_ok);
    logic [12:1] bits;
    bits[1] = 1'b0;
    for (int i = 0; i < 8; i++) bits[2+i] = d[i];
    bits[10] = (~^d) ^ bad_par;
    bits[11] = ~bad_stop;
    bits[12] = 1'b1;
    host_clk = 1'b0;
    repeat (10) @(negedge clk);
    host_dat = 1'b0;
    @(negedge clk);
    host_clk = 1'b1;
    pulses = 0; low_w = 0; ack_seen = 1'b0; busy_ok = 1'b1;
    for (int p = 1; p <= 12; p++) begin
      do @(negedge clk); while (!clk_drive_low);
      pulses++;
      host_dat = bits[p];
      if (!rx_busy) busy_ok = 1'b0;
      if (p == 1) begin
        low_w = 0;
        while (clk_drive_low) begin low_w++; @(negedge clk); end
      end else begin
        do @(negedge clk); while (clk_drive_low);
      end
      if (p == 12) ack_seen = dat_drive_low;
    end
    repeat (HALF + 4) @(negedge clk);
    host_dat = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 clk pin after reset", clk_pin_state, 1);
    check("R11 dat pin after reset", dat_pin_state, 1);
    check("R10 busy idle", rx_busy, 0);
    check("R3 rx_data reset", rx_data, 8'h00);
    check("R9 irq flag reset", rx_irq_flag, 0);
    check("R12 lines released", {clk_drive_low, dat_drive_low}, 2'b00);
  endtask

  task automatic t_pins;
    @(negedge clk); host_dat = 1'b0;
    @(negedge clk);
    check("R11 one cycle still high", dat_pin_state, 1);
    @(negedge clk);
    check("R11 low after two stages", dat_pin_state, 0);
    host_dat = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 back high", dat_pin_state, 1);
  endtask

  task automatic t_basic;
    int pulses, low_w; logic ack, busy_ok;
    host_frame(8'hA5, 1'b0, 1'b0, pulses, low_w, ack, busy_ok);
    check("R2 pulse count", pulses, 12);
    check("R2 low width", low_w, HALF);
    check("R5 ack policy0", ack, 1);
    check("R10 busy during frame", busy_ok, 1);
    check("R10 idle after frame", rx_busy, 0);
    check("R3 byte LSB first", rx_data, 8'hA5);
    check("R4 odd parity bit", rx_parity, 1);
    check("R9 flag set", rx_irq_flag, 1);
    check("R9 irq gated off", rx_irq, 0);
    rx_irq_en = 1'b1; @(negedge clk);
    check("R9 irq when enabled", rx_irq, 1);
    pulse_strobe(3);
    check("R9 flag cleared", rx_irq_flag, 0);
    rx_irq_en = 1'b0;
    pulse_strobe(0);
  endtask

  task automatic t_no_rts;
    host_clk = 1'b0; repeat (10) @(negedge clk);
    host_clk = 1'b1; repeat (40) @(negedge clk);
    check("R1 clock release with data high", {rx_busy, clk_drive_low}, 2'b00);
  endtask

  task automatic t_overwrite;
    int pulses, low_w; logic ack, busy_ok;
    host_frame(8'h11, 1'b0, 1'b0, pulses, low_w, ack, busy_ok);
    check("R8 no overwrite first", overwrite, 0);
    host_frame(8'h22, 1'b0, 1'b0, pulses, low_w, ack, busy_ok);
    check("R8 overwrite set", overwrite, 1);
    check("R8 new byte kept", rx_data, 8'h22);
    check("R4 parity of 0x22", rx_parity, 1);
    pulse_strobe(2);
    check("R8 overwrite cleared", overwrite, 0);
    pulse_strobe(0);
    host_frame(8'h37, 1'b0, 1'b0, pulses, low_w, ack, busy_ok);
    check("R8 read prevents overwrite", overwrite, 0);
    check("R4 parity of 0x37", rx_parity, 0);
    pulse_strobe(0);
    pulse_strobe(3);
  endtask

  task automatic t_bad_parity_policy0;
    int pulses, low_w; logic ack, busy_ok;
    ack_policy = 1'b0;
    host_frame(8'h5E, 1'b1, 1'b0, pulses, low_w, ack, busy_ok);
    check("R5 ack despite bad parity", ack, 1);
    check("R5 byte accepted", rx_data, 8'h5E);
    check("R4 flipped parity kept", rx_parity, 1);
    pulse_strobe(0);
    pulse_strobe(3);
  endtask

  task automatic t_policy1;
    int pulses, low_w; logic ack, busy_ok;
    ack_policy = 1'b1;
    host_frame(8'hC3, 1'b1, 1'b0, pulses, low_w, ack, busy_ok);
    check("R6 no ack bad parity", ack, 0);
    check("R6 byte dropped", rx_data, 8'h5E);
    check("R6 no irq", rx_irq_flag, 0);
    check("R7 no frame err", frame_err, 0);
    host_frame(8'h0F, 1'b0, 1'b1, pulses, low_w, ack, busy_ok);
    check("R6 no ack bad stop", ack, 0);
    check("R7 frame err set", frame_err, 1);
    check("R6 byte dropped stop", rx_data, 8'h5E);
    pulse_strobe(1);
    check("R7 frame err cleared", frame_err, 0);
    host_frame(8'h81, 1'b0, 1'b0, pulses, low_w, ack, busy_ok);
    check("R6 ack good frame", ack, 1);
    check("R6 good byte accepted", rx_data, 8'h81);
    pulse_strobe(0);
    ack_policy = 1'b0;
  endtask

  task automatic t_disable;
    logic saw = 1'b0;
    enable = 1'b0;
    host_clk = 1'b0; repeat (10) @(negedge clk);
    host_dat = 1'b0; @(negedge clk);
    host_clk = 1'b1;
    repeat (60) begin
      @(negedge clk);
      if (clk_drive_low || rx_busy) saw = 1'b1;
    end
    check("R12 request ignored when disabled", saw, 0);
    host_dat = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    enable = 1'b1;
    t_pins();
    t_basic();
    t_no_rts();
    t_overwrite();
    t_bad_parity_policy0();
    t_policy1();
    t_disable();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule